// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital core of a 12-bit successive-approximation converter. A rising edge on an asynchronous start input is brought into the clock domain. The block then places the external track/hold into hold and searches the code space one bit at a time. It drives a trial code to an external DAC and reads back a single comparator decision per step. The converter itself (hold capacitor, DAC, comparator, input scaling) sits outside the block.

While a conversion runs, the active-low busy flag stays low and the result port is not driven. When the frame ends, the final code is stored in a result register and the busy flag returns high. A host reads the code through active-low select and read strobes, in the manner of a processor peripheral.

A power-save input can park the block. The first conversion after wake-up is a throw-away pass: it runs a full frame, but its result is discarded.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A low-to-high change of `conv_start` (set up before a rising clock edge) makes `busy_n` go low and `hold` go high right after the third rising edge that follows. The start input acts the same whatever the levels of `cs_n` and `rd_n`.
- R2: Every conversion keeps `busy_n` low and `hold` high for exactly 27 consecutive clocks: 2 settle clocks, 24 bit clocks and 1 latch clock.
- R3: The search goes from bit 11 down to bit 0, two clocks per bit, starting on the third clock of the frame. During a bit's two clocks, `dac_code` equals the bits already kept OR the trial bit. `cmp_in` sampled at the end of the second clock keeps the bit when it is 1, meaning the input is at or above the trial code. With an ideal comparator the stored result is the straight-binary input code, 1 LSB being full scale / 4096.
- R4: A start edge that arrives while `busy_n` is low is dropped. It neither lengthens the frame nor triggers a later conversion.
- R5: `db_oe` is 1 only when `cs_n`=0, `rd_n`=0, no conversion is running and the block is not powered down. `db_out` then carries the result register; otherwise `db_out` is 0.
- R6: The result register changes only on the latch clock at the end of a conversion. A read attempted during a conversion leaves `db_oe` at 0, and a changing comparator input after the frame leaves the stored code unchanged.
- R7: When `pwr_ok`=0 while `rd_n`=1 and the block is idle, it enters power-down. It stays there, ignoring start edges and never driving the bus, until `pwr_ok` returns to 1. With `rd_n`=0 the entry is held off.
- R8: Entering power-down clears the result register to 0. The first conversion after wake-up runs a full 27-clock frame but leaves the result at 0. The next conversion stores a valid code.
- R9: After reset: `busy_n`=1, `hold`=0, `db_oe`=0, `dac_code`=0 and the result register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Asynchronous start; rising edge begins a conversion |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| pwr_ok | input | 1 | Low requests power-save (with `rd_n` high) |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above trial code |
| dac_code | output | 12 | Trial code for the external DAC |
| hold | output | 1 | High while the track/hold must hold |
| busy_n | output | 1 | Active-low conversion-in-progress flag |
| db_out | output | 12 | Result data toward the bus pads |
| db_oe | output | 1 | Output enable for the bus pads |

## Verification
A wrong bit index or a misplaced comparator sample shows up as a wrong code on the first read after the frame. For a stuck MSB decision that happens within 27 clocks. A counter off by one shows as a busy pulse of 26 or 28 clocks, measured by the monitor the moment `busy_n` rises. Trial codes are also probed on the first two bit steps, so an error in the search order appears within seven clocks of the start. A stuck power-down or dummy flag shows as a non-zero read after wake-up, or as a missing busy pulse, within one conversion.

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int DATA_W      = 12,
  parameter int PRE_CYC     = 2,
  parameter int POST_CYC    = 1,   // must be at least 1
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              pwr_ok,
  input  logic              cmp_in,
  output logic [DATA_W-1:0] dac_code,
  output logic              hold,
  output logic              busy_n,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe
);

  localparam int FRAME   = PRE_CYC + 2*DATA_W + POST_CYC;
  localparam int CNT_W   = $clog2(FRAME + 1);
  localparam int BIT_END = PRE_CYC + 2*DATA_W;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_PDOWN} state_t;

  state_t              state;
  logic [SYNC_STAGES:0] sync_q;
  logic [CNT_W-1:0]    cnt;
  logic [DATA_W-1:0]   sar;
  logic [DATA_W-1:0]   result;
  logic                dummy;

  wire start_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  wire converting = (state == S_CONV);
  wire in_bits    = converting && (cnt >= CNT_W'(PRE_CYC)) && (cnt < CNT_W'(BIT_END));

  logic [CNT_W-1:0]  offs;
  logic [DATA_W-1:0] trial;
  assign offs  = cnt - CNT_W'(PRE_CYC);
  assign trial = {{(DATA_W-1){1'b0}}, 1'b1} << (DATA_W - 1 - int'(offs >> 1));

  wire decide = in_bits && offs[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      state  <= S_IDLE;
      cnt    <= '0;
      sar    <= '0;
      result <= '0;
      dummy  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], conv_start};
      case (state)
        S_IDLE: begin
          if (!pwr_ok && rd_n) begin
            state  <= S_PDOWN;
            result <= '0;
            dummy  <= 1'b1;
          end else if (start_rise) begin
            state <= S_CONV;
            cnt   <= '0;
            sar   <= '0;
          end
        end
        S_CONV: begin
          cnt <= cnt + 1'b1;
          if (decide && cmp_in) sar <= sar | trial;
          if (cnt == CNT_W'(FRAME - 1)) begin
            state <= S_IDLE;
            if (!dummy) result <= sar;
            dummy <= 1'b0;
          end
        end
        S_PDOWN: begin
          if (pwr_ok) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dac_code = in_bits ? (sar | trial) : (converting ? sar : '0);
  assign hold     = converting;
  assign busy_n   = ~converting;
  assign db_oe    = (state == S_IDLE) && !cs_n && !rd_n;
  assign db_out   = db_oe ? result : '0;

  logic [CNT_W-1:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_len <= '0;
    else if (busy_n) low_len <= '0;
    else             low_len <= low_len + 1'b1;
  end

  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_len == CNT_W'(FRAME)));

  p_start_from_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(sync_q[SYNC_STAGES-1]));

  p_no_drive_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !db_oe);

  p_oe_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe |-> (!cs_n && !rd_n));

  p_result_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && $past(busy_n) && db_oe && $past(db_oe)) |-> $stable(db_out));

  p_pdown_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PDOWN) |-> (busy_n && !db_oe));

endmodule

// File: tb/test_sar_conv_ctrl.sv
`timescale 1ns/100ps
module test_sar_conv_ctrl;
  localparam int W = 12;
  localparam int FRAME = 27;

  logic clk = 0, rst_n = 0, conv_start = 0, cs_n = 1, rd_n = 1, pwr_ok = 1;
  logic [W-1:0] target = '0;
  logic [W-1:0] dac_code, db_out;
  logic hold, busy_n, db_oe;
  wire cmp_in = (dac_code <= target);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cs_n(cs_n), .rd_n(rd_n),
    .pwr_ok(pwr_ok), .cmp_in(cmp_in), .dac_code(dac_code), .hold(hold),
    .busy_n(busy_n), .db_out(db_out), .db_oe(db_oe));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: frame length and bus reads against the scoreboard
  initial begin
    int run;
    logic [W-1:0] e;
    run = 0;
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (!busy_n) run++;
        else if (run != 0) begin
          check(run == FRAME && hold == 0, "R2 busy frame length", run, FRAME);
          run = 0;
        end
        if (db_oe) begin
          if (exp_q.size() == 0) check(0, "R5 unexpected bus drive", int'(db_out), 0);
          else begin
            e = exp_q.pop_front();
            check(db_out == e, "R3 R8 read value", int'(db_out), int'(e));
          end
        end
      end
    end
  end

  task automatic read_expect(input logic [W-1:0] e);
    exp_q.push_back(e);
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy_n == 0 && n < 100) begin @(negedge clk); n++; end
    check(busy_n == 1, "R2 conversion ends", busy_n, 1);
  endtask

  task automatic start_conv(input logic [W-1:0] t);
    target = t;
    @(negedge clk); conv_start = 1;
    @(negedge clk);
    @(negedge clk); check(busy_n == 1, "R1 busy still high after two edges", busy_n, 1);
    @(negedge clk); check(busy_n == 0 && hold == 1, "R1 busy low after third edge", busy_n, 0);
    conv_start = 0;
    @(negedge clk);
    @(negedge clk); check(dac_code == 12'h800, "R3 MSB trial first", int'(dac_code), 'h800);
    @(negedge clk);
    @(negedge clk); check(dac_code == ((t & 12'h800) | 12'h400), "R3 second trial",
                          int'(dac_code), int'((t & 12'h800) | 12'h400));
  endtask

  task automatic convert_read(input logic [W-1:0] t, input logic [W-1:0] e);
    start_conv(t);
    wait_idle();
    read_expect(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(busy_n == 1 && hold == 0 && db_oe == 0 && dac_code == 0, "R9 reset outputs", busy_n, 1);
    rst_n = 1;
    @(negedge clk);
    read_expect(12'h000);                          // R9 result cleared

    convert_read(12'hABC, 12'hABC);                // R3 patterns
    convert_read(12'h000, 12'h000);
    convert_read(12'hFFF, 12'hFFF);
    convert_read(12'h800, 12'h800);
    convert_read(12'h7FF, 12'h7FF);
    convert_read(12'h001, 12'h001);
    convert_read(12'h555, 12'h555);

    // R6: read attempt mid-frame, then comparator change after the frame
    start_conv(12'h3A6);
    cs_n = 0; rd_n = 0;
    repeat (3) begin
      @(negedge clk); check(db_oe == 0, "R6 no drive during conversion", db_oe, 0);
    end
    cs_n = 1; rd_n = 1;
    // R4: second start edge while busy
    @(negedge clk); conv_start = 1;
    repeat (4) @(negedge clk);
    conv_start = 0;
    wait_idle();
    repeat (10) @(negedge clk);
    check(busy_n == 1, "R4 start while busy ignored", busy_n, 1);
    target = 12'h0F0;
    read_expect(12'h3A6);
    read_expect(12'h3A6);                          // R6 stored code steady

    // R1: start is independent of select and read
    cs_n = 0; rd_n = 1;
    start_conv(12'h123);
    cs_n = 1;
    wait_idle();
    read_expect(12'h123);

    // R7: entry held off while rd_n low
    exp_q.push_back(12'h123);
    @(negedge clk); cs_n = 0; rd_n = 0; pwr_ok = 0;
    @(negedge clk); cs_n = 1; rd_n = 1;
    repeat (3) @(negedge clk);
    cs_n = 0; rd_n = 0;
    @(negedge clk); check(db_oe == 0, "R7 no bus drive in power-down", db_oe, 0);
    cs_n = 1; rd_n = 1;
    conv_start = 1;
    repeat (4) @(negedge clk);
    conv_start = 0;
    repeat (10) @(negedge clk);
    check(busy_n == 1, "R7 start ignored in power-down", busy_n, 1);
    pwr_ok = 1;
    repeat (3) @(negedge clk);

    // R8: dummy conversion then valid one
    convert_read(12'h3C3, 12'h000);
    convert_read(12'h3C3, 12'h3C3);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all expected reads driven", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule